// File: doc/BRIEF.md
# Registered Unsigned Array Multiplier

This block multiplies two unsigned operands and returns their full-width product. Both operands are first captured in clocked registers. A regular array then forms the product without a multiply operator. Each row of the array gates the A operand with one bit of B, which gives one shifted summand. A row of adder cells adds that summand to the running partial sum. The least significant bit of each row's result is final and leaves the array at that row. The bits left over after the last row form the upper half of the product.

The product is stored in its own register. A value presented on the operand ports therefore appears at the product port two rising edges later. The register that holds the product is loaded from the array one edge after the operands are captured. An active-low asynchronous reset clears the operand registers and the product register. The widths of both operands are parameters; the defaults are 8 and 8, which give a 16-bit product.

Top module: `arr_mul_reg`

## Requirements
- R1: While `rst_n` is low, `p_out` reads zero, and it goes to zero as soon as reset is asserted, without waiting for a clock edge.
- R2: Outside reset, `p_out` after rising edge k equals the unsigned product of the `a_in` and `b_in` values sampled at rising edge k-1.
- R3: The operands are treated as unsigned: 255 x 255 gives 65025 (0xFE01), with no sign extension of any summand.
- R4: Bit 0 of the product equals the AND of bit 0 of A and bit 0 of B.
- R5: If either operand is zero, the product is zero.
- R6: If B is 1, the product equals A, zero-extended to the product width.
- R7: If B is 2^i, the product equals A shifted left by i places. This shows that each summand is placed by its bit of B.
- R8: With operands that fit in 4 bits, A=12 and B=11 give a product of 132.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Active-low asynchronous clear |
| a_in | input | WA (8) | Multiplicand, unsigned |
| b_in | input | WB (8) | Multiplier, unsigned |
| p_out | output | WA+WB (16) | Registered product |

## Verification
The bench checks the two-edge latency on every cycle. A design that dropped or added a register stage would compare against the product of the wrong operand pair. Operands with all bits set expose any summand that is sign-extended, and any carry that is lost at the top of a row; either fault would corrupt the upper product bits. Walking single-bit values of B show whether a summand is placed at the wrong shift, and zero and one operands catch gating faults. Reset is asserted between clock edges, so a reset that acted only on an edge would leave a stale product visible.

// File: rtl/arr_mul_pkg.sv
package arr_mul_pkg;

   typedef struct packed {
      logic s;
      logic co;
   } fa_res_t;

   function automatic fa_res_t fa_eval(input logic x, input logic y, input logic ci);
      fa_res_t r;
      r.s  = x ^ y ^ ci;
      r.co = (x & y) | (ci & (x ^ y));
      return r;
   endfunction

endpackage

// File: rtl/am_fa_cell.sv
module am_fa_cell (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   import arr_mul_pkg::*;
   fa_res_t r;
   always_comb r = fa_eval(x, y, ci);
   assign s  = r.s;
   assign co = r.co;
endmodule

// File: rtl/am_pp_row.sv
module am_pp_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         b_bit,
   output logic [W-1:0] pp
);
   assign pp = a & {W{b_bit}};
endmodule

// File: rtl/am_add_row.sv
module am_add_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] acc,
   input  logic [W-1:0] pp,
   output logic [W:0]   sum
);
   logic [W-1:0] cy;

   for (genvar j = 0; j < W; j++) begin : g_cell
      if (j == 0) begin : g_half
         // carry-in is a constant zero here, so a half adder suffices
         assign sum[0] = acc[0] ^ pp[0];
         assign cy[0]  = acc[0] & pp[0];
      end else begin : g_full
         am_fa_cell u_fa (
            .x  (acc[j]),
            .y  (pp[j]),
            .ci (cy[j-1]),
            .s  (sum[j]),
            .co (cy[j])
         );
      end
   end

   assign sum[W] = cy[W-1];
endmodule

// File: rtl/am_reg.sv
module am_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/arr_mul_reg.sv
module arr_mul_reg #(
   parameter int WA = 8,
   parameter int WB = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WA-1:0]    a_in,
   input  logic [WB-1:0]    b_in,
   output logic [WA+WB-1:0] p_out
);
   localparam int PW = WA + WB;

   if (WA < 2) begin : g_bad_wa
      $error("arr_mul_reg: WA must be at least 2");
   end
   if (WB < 2) begin : g_bad_wb
      $error("arr_mul_reg: WB must be at least 2");
   end

   logic [WA-1:0] a_q;
   logic [WB-1:0] b_q;
   logic [PW-1:0] p_d;

   am_reg #(.W(WA)) u_areg (.clk(clk), .rst_n(rst_n), .d(a_in), .q(a_q));
   am_reg #(.W(WB)) u_breg (.clk(clk), .rst_n(rst_n), .d(b_in), .q(b_q));

   logic [WA-1:0] pp   [WB];
   logic [WA:0]   rsum [WB];

   for (genvar i = 0; i < WB; i++) begin : g_row
      am_pp_row #(.W(WA)) u_pp (.a(a_q), .b_bit(b_q[i]), .pp(pp[i]));
      if (i == 0) begin : g_first
         assign rsum[0] = {1'b0, pp[0]};
      end else begin : g_add
         am_add_row #(.W(WA)) u_add (
            .acc (rsum[i-1][WA:1]),
            .pp  (pp[i]),
            .sum (rsum[i])
         );
      end
      assign p_d[i] = rsum[i][0];
   end

   assign p_d[PW-1:WB] = rsum[WB-1][WA:1];

   am_reg #(.W(PW)) u_preg (.clk(clk), .rst_n(rst_n), .d(p_d), .q(p_out));
endmodule

// File: rtl/arr_mul_chk.sv
module arr_mul_chk #(
   parameter int WA = 8,
   parameter int WB = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WA-1:0]    a_q,
   input logic [WB-1:0]    b_q,
   input logic [WA+WB-1:0] p_out
);
   localparam int PW = WA + WB;

   logic          seen;
   logic [PW-1:0] ref_p;
   logic [WA-1:0] pa;
   logic [WB-1:0] pb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= 1'b0;
         ref_p <= '0;
         pa    <= '0;
         pb    <= '0;
      end else begin
         seen  <= 1'b1;
         ref_p <= PW'(a_q) * PW'(b_q);
         pa    <= a_q;
         pb    <= b_q;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) AST_RESET_CLEAR: assert (p_out == '0 && a_q == '0 && b_q == '0); // R1
   end

   AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> p_out == ref_p); // R2
   AST_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> p_out[0] == (pa[0] & pb[0])); // R4
   AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (pa == '0 || pb == '0)) |-> p_out == '0); // R5
   AST_UNIT_MULT: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && pb == WB'(1)) |-> p_out == PW'(pa)); // R6
   AST_POW2_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $countones(pb) == 1) |-> $countones(p_out) == $countones(pa)); // R7
endmodule

bind arr_mul_reg arr_mul_chk #(.WA(WA), .WB(WB)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .a_q   (a_q),
   .b_q   (b_q),
   .p_out (p_out)
);

// File: tb/tb_arr_mul_reg.sv
module tb_arr_mul_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a_in = '0;
   logic [7:0]  b_in = '0;
   logic [15:0] p_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   arr_mul_reg dut (.clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .p_out(p_out));

   // behavioural reference: operand stage then product stage
   int ma, mb, pa, pb, mp;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma <= 0; mb <= 0; pa <= 0; pb <= 0; mp <= 0;
      end else begin
         mp <= ma * mb;
         pa <= ma; pb <= mb;
         ma <= a_in; mb <= b_in;
      end
   end

   function automatic string tag_of(int x, int y);
      if (x == 12 && y == 11) return "R8";
      if (x == 255 && y == 255) return "R3";
      if (x == 0 || y == 0) return "R5";
      if (y == 1) return "R6";
      if (y != 0 && (y & (y - 1)) == 0) return "R7";
      return "R2";
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(int x, int y);
      @(negedge clk);
      if (rst_n) begin
         check(tag_of(pa, pb), int'(p_out), mp);
         check("R4", int'(p_out[0]), (pa & pb) & 1);
      end
      a_in = 8'(x);
      b_in = 8'(y);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(p_out), 0);
      rst_n = 1'b1;
      cyc(12, 11);
      cyc(255, 255);
      cyc(0, 200);
      cyc(173, 0);
      cyc(91, 1);
      cyc(255, 1);
      for (int i = 0; i < 8; i++) cyc(255, 1 << i);
      for (int i = 0; i < 8; i++) cyc(1 << i, 255);
      cyc(12, 11);
      cyc(128, 128);
      cyc(1, 1);
      for (int i = 0; i < 3000; i++) cyc(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      cyc(255, 255);
      cyc(200, 199);
      cyc(0, 0);
      // asynchronous clear between edges while a nonzero product is held
      cyc(250, 250);
      cyc(250, 250);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #0.5 check("R1", int'(p_out), 0);
      @(negedge clk);
      check("R1", int'(p_out), 0);
      rst_n = 1'b1;
      cyc(12, 11);
      cyc(3, 5);
      cyc(0, 0);
      cyc(0, 0);
      finish_run();
   end
endmodule